// File: doc/BRIEF.md
# Reset and Stop-Recovery Sequencer

This block times the reset and low-power wake-up phases of a small controller. A single counter, clocked by the falling edge of the doubled oscillator signal, serves three purposes. It stretches internal resets: the open-drain reset pin is driven low for a full counter period, and the CPU and memories are then held a further short interval. It times oscillator settling after STOP, so that the internal bus clocks come back only after a short or a long delay. It also supplies a one-cycle tick, once per counter wrap, to drive a watchdog.

Internal reset sources are the low-voltage trip and the watchdog timeout. A reset applied from outside on the pin holds the CPU in reset only while it is present, and it leaves the counter untouched. Each source sets its own bit in a status vector. A read strobe clears that vector.

Top module: `rst_stop_seq`

## Requirements
- R1: While `porN` is low, `rstPinDriveLow`=1, `cpuRstN`=0, `busClkEn`=1 and `statusFlags`=4'b0001 (bit0 power-on, bit1 low-voltage, bit2 watchdog, bit3 external). After release, the pin is driven for 4095 further cycles and the CPU is released 64 cycles after that.
- R2: An internal source (`lowVoltTrip` or `wdogTrip`) sampled at a falling edge drives `rstPinDriveLow` high for exactly 4096 cycles, starting the following cycle.
- R3: `cpuRstN` stays low during the pin-low interval and for 64 more cycles, then rises.
- R4: An internal source that asserts during a reset stretch restarts the 4096-cycle pin-low count from zero.
- R5: Each status bit is set only by its own source (bit1 low-voltage, bit2 watchdog, bit3 external). `statusRead` clears all bits on the next edge, and a set on that same edge wins.
- R6: `stopReq` in normal running clears the counter and drops `busClkEn` on the next cycle.
- R7: `wakeEvt` during stop samples `shortRecCfg` once. `busClkEn` is still low 32 cycles after the wake edge (value 1) or 4096 cycles after it (value 0), and it is high one cycle later. Later changes to `shortRecCfg` have no effect on a recovery already under way.
- R8: `extPinLow` holds `cpuRstN` low while asserted and releases it one cycle after removal. It never drives the pin and does not disturb the counter.
- R9: `wdogTick` is a one-cycle pulse, repeating every 4096 cycles while the counter runs freely.
- R10: An internal source asserted during stop ends the stop at once: the pin goes low and `busClkEn` returns high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Doubled oscillator clock; falling edge is active |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| lowVoltTrip | input | 1 | Low-voltage detector trip |
| wdogTrip | input | 1 | Watchdog timeout reset request |
| extPinLow | input | 1 | Reset pin sensed low from outside |
| stopReq | input | 1 | STOP executed |
| wakeEvt | input | 1 | Interrupt, break or reset wake event |
| shortRecCfg | input | 1 | 1 selects 32-cycle stop recovery, 0 selects 4096 |
| statusRead | input | 1 | Read of status vector; clears flags |
| rstPinDriveLow | output | 1 | Open-drain pull-down enable for reset pin |
| cpuRstN | output | 1 | CPU and memory reset, active low |
| busClkEn | output | 1 | Internal bus clock enable |
| wdogTick | output | 1 | Watchdog prescaler tick |
| statusFlags | output | 4 | Reset cause flags |

## Verification
Every result is registered on the falling edge that samples its cause. The bench therefore drives just after a rising edge and samples just after later rising edges, with N edges of delay counted as N samples. The pin asserts one sample after a trip and releases at sample 4097. The CPU is released at sample 4161, and bus clocks return at sample 33 or 4097 after a wake. Each boundary is checked on both sides, one sample before and at the expected change. Tick spacing across an external reset is measured by counting samples between pulses.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_PINLOW, ST_HOLD, ST_STOPPED, ST_WAKE, ST_EXTRST
  } seqState_t;

  typedef struct packed {
    logic cntClear;
    logic cntFreeze;
    logic setLowVolt;
    logic setWdog;
    logic setExt;
  } seqStrobe_t;
endpackage

// File: rtl/rst_seq_datapath.sv
module rst_seq_datapath
  import rst_seq_pkg::*;
#(
  parameter int CNT_STAGES = 12,
  parameter int HOLD_CYC   = 64,
  parameter int SHORT_CYC  = 32
) (
  input  logic       clk2x,
  input  logic       porN,
  input  seqStrobe_t strobe,
  input  logic       statusRead,
  input  logic       shortSel,
  output logic       cntAtFull,
  output logic       cntAtHold,
  output logic       cntAtWake,
  output logic       cntIsZero,
  output logic       wdogTick,
  output logic [3:0] statusFlags
);
  localparam int NUM_SRC = 3;
  localparam logic [CNT_STAGES-1:0] HOLD_LAST  = CNT_STAGES'(HOLD_CYC - 1);
  localparam logic [CNT_STAGES-1:0] SHORT_LAST = CNT_STAGES'(SHORT_CYC - 1);

  logic [CNT_STAGES-1:0] cnt;
  logic [NUM_SRC-1:0]    srcFlag;
  logic [NUM_SRC-1:0]    setVec;
  logic                  porFlag;

  assign cntAtFull = &cnt;
  assign cntAtHold = (cnt == HOLD_LAST);
  assign cntIsZero = (cnt == '0);
  assign cntAtWake = shortSel ? (cnt == SHORT_LAST) : cntAtFull;

  // counting stages plus carry stage feeding the watchdog tick
  always_ff @(negedge clk2x or negedge porN) begin
    if (!porN) begin
      cnt      <= '0;
      wdogTick <= 1'b0;
    end else if (strobe.cntClear) begin
      cnt      <= '0;
      wdogTick <= 1'b0;
    end else if (strobe.cntFreeze) begin
      wdogTick <= 1'b0;
    end else begin
      cnt      <= cnt + 1'b1;
      wdogTick <= cntAtFull;
    end
  end

  assign setVec = {strobe.setExt, strobe.setWdog, strobe.setLowVolt};

  generate
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_flag
      always_ff @(negedge clk2x or negedge porN) begin
        if (!porN)            srcFlag[gi] <= 1'b0;
        else if (setVec[gi])  srcFlag[gi] <= 1'b1;
        else if (statusRead)  srcFlag[gi] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(negedge clk2x or negedge porN) begin
    if (!porN)           porFlag <= 1'b1;
    else if (statusRead) porFlag <= 1'b0;
  end

  assign statusFlags = {srcFlag, porFlag};

  // R9
  tick_single_chk: assert property (@(negedge clk2x) disable iff (!porN)
    wdogTick |=> !wdogTick);
  // R5
  lv_flag_source_chk: assert property (@(negedge clk2x) disable iff (!porN)
    $rose(statusFlags[1]) |-> $past(strobe.setLowVolt));
  // R5
  read_clears_chk: assert property (@(negedge clk2x) disable iff (!porN)
    (statusRead && !(|setVec)) |=> (statusFlags == 4'b0000));
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk2x,
  input  logic       porN,
  input  logic       lowVoltTrip,
  input  logic       wdogTrip,
  input  logic       extPinLow,
  input  logic       stopReq,
  input  logic       wakeEvt,
  input  logic       shortRecCfg,
  input  logic       cntAtFull,
  input  logic       cntAtHold,
  input  logic       cntAtWake,
  input  logic       cntIsZero,
  output seqStrobe_t strobe,
  output logic       shortSel,
  output logic       rstPinDriveLow,
  output logic       cpuRstN,
  output logic       busClkEn
);
  seqState_t st, stNext;
  logic      intTrip;

  assign intTrip = lowVoltTrip | wdogTrip;

  always_comb begin
    stNext            = st;
    strobe            = '0;
    strobe.setLowVolt = lowVoltTrip;
    strobe.setWdog    = wdogTrip;
    strobe.setExt     = extPinLow && !intTrip && (st != ST_PINLOW);
    if (intTrip) begin
      stNext          = ST_PINLOW;
      strobe.cntClear = 1'b1;
    end else if (extPinLow && st != ST_PINLOW) begin
      stNext = ST_EXTRST;
    end else begin
      unique case (st)
        ST_RUN: if (stopReq) begin
          stNext          = ST_STOPPED;
          strobe.cntClear = 1'b1;
        end
        ST_PINLOW:  if (cntAtFull) stNext = ST_HOLD;
        ST_HOLD:    if (cntAtHold) stNext = ST_RUN;
        ST_STOPPED: begin
          strobe.cntFreeze = 1'b1;
          if (wakeEvt) stNext = ST_WAKE;
        end
        ST_WAKE:    if (cntAtWake) stNext = ST_RUN;
        ST_EXTRST:  stNext = ST_RUN;
        default:    stNext = ST_RUN;
      endcase
    end
  end

  always_ff @(negedge clk2x or negedge porN) begin
    if (!porN) begin
      st       <= ST_PINLOW;
      shortSel <= 1'b0;
    end else begin
      st <= stNext;
      if (st == ST_STOPPED && stNext == ST_WAKE) shortSel <= shortRecCfg;
    end
  end

  assign rstPinDriveLow = (st == ST_PINLOW);
  assign cpuRstN        = !(st == ST_PINLOW || st == ST_HOLD || st == ST_EXTRST);
  assign busClkEn       = !(st == ST_STOPPED || st == ST_WAKE);

  // R4
  restart_stretch_chk: assert property (@(negedge clk2x) disable iff (!porN)
    intTrip |=> (rstPinDriveLow && cntIsZero));
  // R3
  cpu_release_chk: assert property (@(negedge clk2x) disable iff (!porN)
    $rose(cpuRstN) |-> $past(st == ST_HOLD || st == ST_EXTRST));
  // R6
  stop_gates_bus_chk: assert property (@(negedge clk2x) disable iff (!porN)
    (st == ST_RUN && stopReq && !intTrip && !extPinLow) |=> !busClkEn);
  // R7
  bus_return_chk: assert property (@(negedge clk2x) disable iff (!porN)
    $rose(busClkEn) |-> $past((st == ST_WAKE && cntAtWake) || intTrip || extPinLow));
endmodule

// File: rtl/rst_stop_seq.sv
module rst_stop_seq
  import rst_seq_pkg::*;
#(
  parameter int CNT_STAGES = 12,
  parameter int HOLD_CYC   = 64,
  parameter int SHORT_CYC  = 32
) (
  input  logic       clk2x,
  input  logic       porN,
  input  logic       lowVoltTrip,
  input  logic       wdogTrip,
  input  logic       extPinLow,
  input  logic       stopReq,
  input  logic       wakeEvt,
  input  logic       shortRecCfg,
  input  logic       statusRead,
  output logic       rstPinDriveLow,
  output logic       cpuRstN,
  output logic       busClkEn,
  output logic       wdogTick,
  output logic [3:0] statusFlags
);
  seqStrobe_t strobe;
  logic shortSel, cntAtFull, cntAtHold, cntAtWake, cntIsZero;

  rst_seq_ctrl u_ctrl (
    .clk2x(clk2x), .porN(porN), .lowVoltTrip(lowVoltTrip), .wdogTrip(wdogTrip),
    .extPinLow(extPinLow), .stopReq(stopReq), .wakeEvt(wakeEvt),
    .shortRecCfg(shortRecCfg), .cntAtFull(cntAtFull), .cntAtHold(cntAtHold),
    .cntAtWake(cntAtWake), .cntIsZero(cntIsZero), .strobe(strobe),
    .shortSel(shortSel), .rstPinDriveLow(rstPinDriveLow), .cpuRstN(cpuRstN),
    .busClkEn(busClkEn)
  );

  rst_seq_datapath #(
    .CNT_STAGES(CNT_STAGES), .HOLD_CYC(HOLD_CYC), .SHORT_CYC(SHORT_CYC)
  ) u_dp (
    .clk2x(clk2x), .porN(porN), .strobe(strobe), .statusRead(statusRead),
    .shortSel(shortSel), .cntAtFull(cntAtFull), .cntAtHold(cntAtHold),
    .cntAtWake(cntAtWake), .cntIsZero(cntIsZero), .wdogTick(wdogTick),
    .statusFlags(statusFlags)
  );
endmodule

// File: tb/sim_rst_stop_seq.sv
module sim_rst_stop_seq;
  logic clk = 1'b0;
  logic porN = 1'b0, lowVoltTrip = 1'b0, wdogTrip = 1'b0, extPinLow = 1'b0;
  logic stopReq = 1'b0, wakeEvt = 1'b0, shortRecCfg = 1'b0, statusRead = 1'b0;
  logic rstPinDriveLow, cpuRstN, busClkEn, wdogTick;
  logic [3:0] statusFlags;
  int nChk = 0, nBad = 0;

  always #5 clk = ~clk;

  rst_stop_seq u0 (
    .clk2x(clk), .porN(porN), .lowVoltTrip(lowVoltTrip), .wdogTrip(wdogTrip),
    .extPinLow(extPinLow), .stopReq(stopReq), .wakeEvt(wakeEvt),
    .shortRecCfg(shortRecCfg), .statusRead(statusRead),
    .rstPinDriveLow(rstPinDriveLow), .cpuRstN(cpuRstN), .busClkEn(busClkEn),
    .wdogTick(wdogTick), .statusFlags(statusFlags)
  );

  // wake table: bit13 = short-recovery config, bits 12:0 = cycles busClkEn stays low
  localparam logic [13:0] WAKE_VEC [3] = '{
    {1'b1, 13'd32}, {1'b0, 13'd4096}, {1'b1, 13'd32}
  };

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic readClear();
    statusRead = 1'b1; step(1); statusRead = 1'b0;
  endtask

  initial begin
    #1500000;
    nBad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int gap;
    step(3);
    // R1 reset state
    check("R1 pin", rstPinDriveLow, 1);
    check("R1 cpu", cpuRstN, 0);
    check("R1 bus", busClkEn, 1);
    check("R1 flags", statusFlags, 4'b0001);
    porN = 1'b1;
    step(4095); check("R1 pin before end", rstPinDriveLow, 1);
    step(1);    check("R1 pin end", rstPinDriveLow, 0);
    step(63);   check("R1 cpu held", cpuRstN, 0);
    step(1);    check("R1 cpu released", cpuRstN, 1);

    // R5 read clears
    readClear();
    check("R5 read clears", statusFlags, 4'b0000);

    // R2 R3 low-voltage stretch
    lowVoltTrip = 1'b1; step(1); lowVoltTrip = 1'b0;
    check("R2 pin asserted", rstPinDriveLow, 1);
    check("R5 lv flag only", statusFlags, 4'b0010);
    step(4095); check("R2 pin last low", rstPinDriveLow, 1);
    step(1);    check("R2 pin released", rstPinDriveLow, 0);
    check("R3 cpu held after pin", cpuRstN, 0);
    step(63);   check("R3 cpu still held", cpuRstN, 0);
    step(1);    check("R3 cpu released", cpuRstN, 1);

    // R4 retrigger by watchdog source
    readClear();
    wdogTrip = 1'b1; step(1); wdogTrip = 1'b0;
    step(999);
    wdogTrip = 1'b1; step(1); wdogTrip = 1'b0;
    check("R5 wd flag only", statusFlags, 4'b0100);
    step(3099); check("R4 still low after old end", rstPinDriveLow, 1);
    step(996);  check("R4 last low", rstPinDriveLow, 1);
    step(1);    check("R4 released", rstPinDriveLow, 0);
    step(65);   check("R3 cpu after retrigger", cpuRstN, 1);

    // R9 R8 tick spacing across external reset
    readClear();
    gap = 0;
    while (wdogTick !== 1'b1 && gap < 5000) begin step(1); gap++; end
    step(1); check("R9 tick width", wdogTick, 0);
    step(99);
    extPinLow = 1'b1; step(1);
    check("R8 cpu in reset", cpuRstN, 0);
    check("R8 pin not driven", rstPinDriveLow, 0);
    step(4); extPinLow = 1'b0; step(1);
    check("R8 cpu released", cpuRstN, 1);
    check("R5 ext flag only", statusFlags, 4'b1000);
    gap = 106;
    while (wdogTick !== 1'b1 && gap < 6000) begin step(1); gap++; end
    check("R8 R9 tick period", gap, 4096);

    // R6 R7 stop/wake table
    foreach (WAKE_VEC[i]) begin
      stopReq = 1'b1; step(1); stopReq = 1'b0;
      check("R6 bus gated", busClkEn, 0);
      step(10);
      shortRecCfg = WAKE_VEC[i][13]; wakeEvt = 1'b1; step(1);
      wakeEvt = 1'b0; shortRecCfg = ~WAKE_VEC[i][13];
      step(int'(WAKE_VEC[i][12:0]) - 1);
      check("R7 bus still low", busClkEn, 0);
      step(1);
      check("R7 bus back", busClkEn, 1);
    end

    // R10 internal reset during stop
    stopReq = 1'b1; step(1); stopReq = 1'b0;
    step(5);
    lowVoltTrip = 1'b1; step(1); lowVoltTrip = 1'b0;
    check("R10 bus restored", busClkEn, 1);
    check("R10 pin low", rstPinDriveLow, 1);
    step(4161);
    check("R10 cpu released", cpuRstN, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule